// File: doc/BRIEF.md
# Split-Byte DAC Code Register Front-End

This block is the digital side of a 12-bit voltage converter. Software reaches it over an 8-bit write bus with three registers: a low data byte, a high data byte and a control byte. The two data bytes are kept exactly as they were written. When an update event happens, the block aligns them into a 12-bit code using one of five justification formats and loads that code into a separate output register. The converter input is driven from that register. A code of 0x000 stands for zero output and 0xFFF for the full reference.

The control byte selects the update event. It can be a write to the high byte, or a single-cycle overflow pulse from one of three external timers. The same byte holds the justification format and an enable bit. The enable bit drives a shutdown output, and that output also puts the analog pin into high impedance. Software writes the low byte first and the high byte second. In timer modes the code then waits for the next selected overflow pulse. The format is read at the moment of the event, so the alignment can be changed up to that point.

Top module: `dacfe_top`

## Requirements
- R1: After reset, `dac_code` is 0x000, `dac_shdn` is 1, and a read at every register select returns 0x00.
- R2: Control bit 7 is the enable. At the clock edge that takes a control write, `dac_shdn` becomes the inverse of that bit.
- R3: Control bits 6:5 have no storage. A read of the control register always returns 0 in those bits, whatever was written there.
- R4: Select 0 reads the low byte, select 1 the high byte and select 2 the control byte, each as last written. Select 3 reads 0x00, and a write to select 3 changes nothing.
- R5: A write to the low byte never changes `dac_code`.
- R6: With control bits 4:3 = 00, `dac_code` updates at the same edge that takes a high-byte write. The new code is built from the newly written high byte and the stored low byte.
- R7: With control bits 4:3 = 01, 10 or 11, the update happens at the edge where `tmr_ovf[0]`, `tmr_ovf[1]` or `tmr_ovf[2]` is high, in that order. In these modes a high-byte write and the pulses of the other two timers leave `dac_code` unchanged.
- R8: Control bits 2:0 are the format. With a shift s equal to bits 2:0 when bit 2 is 0, and 4 when bit 2 is 1, the code is bits 11:0 of the 16-bit value {high, low} shifted right by s.
- R9: The format in force at the update event decides the code. Changing the format without an event leaves `dac_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_sel | input | 2 | Register select: 0 low byte, 1 high byte, 2 control, 3 none |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| tmr_ovf | input | 3 | Single-cycle timer overflow pulses |
| dac_code | output | 12 | Code presented to the converter |
| dac_shdn | output | 1 | Shutdown and high-impedance control, high when disabled |

## Verification
The bench builds the block with its default 8-bit bytes, 12-bit code and three timer inputs. At that size all eight format codes can be swept against 256 high/low byte pairs in high-byte-write mode, which covers every shift and every boundary between the two bytes. Each timer mode is then checked with pulses from the selected timer and from the other two. The bench also checks that a late format change is honoured at the event and has no effect before it.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    UPD_HIWR  = 2'd0,
    UPD_OVF_A = 2'd1,
    UPD_OVF_B = 2'd2,
    UPD_OVF_C = 2'd3
  } upd_src_e;

  typedef struct packed {
    logic       en;
    upd_src_e   src;
    logic [2:0] fmt;
  } ctrl_t;

  localparam int CTRL_EN_BIT = 7;

endpackage

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output ctrl_t             ctrl_q,
  output logic              hi_wr,
  output logic [BYTE_W-1:0] rdata
);

  logic              lo_ce, hi_ce, ctrl_ce;
  logic [BYTE_W-1:0] lo_d, hi_d;
  ctrl_t             ctrl_d;

  always_comb begin
    lo_ce   = wr_en && (sel == SEL_LO);
    hi_ce   = wr_en && (sel == SEL_HI);
    ctrl_ce = wr_en && (sel == SEL_CTRL);
    lo_d    = lo_ce ? wdata : lo_q;
    hi_d    = hi_ce ? wdata : hi_q;
    ctrl_d  = ctrl_q;
    if (ctrl_ce) begin
      ctrl_d.en  = wdata[CTRL_EN_BIT];
      ctrl_d.src = upd_src_e'(wdata[4:3]);
      ctrl_d.fmt = wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      ctrl_q <= '0;
    end else begin
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign hi_wr = hi_ce;

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_LO:   rdata = lo_q;
      SEL_HI:   rdata = hi_q;
      SEL_CTRL: begin
        rdata[CTRL_EN_BIT] = ctrl_q.en;
        rdata[4:3]         = ctrl_q.src;
        rdata[2:0]         = ctrl_q.fmt;
      end
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/dacfe_align.sv
module dacfe_align #(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 12
) (
  input  logic [BYTE_W-1:0] hi_byte,
  input  logic [BYTE_W-1:0] lo_byte,
  input  logic [2:0]        fmt,
  output logic [CODE_W-1:0] code
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int MAX_SH = WORD_W - CODE_W;

  logic [WORD_W-1:0] word;
  logic [CODE_W-1:0] cand [MAX_SH+1];
  int unsigned       sh;

  assign word = {hi_byte, lo_byte};

  for (genvar s = 0; s <= MAX_SH; s++) begin : g_shift
    assign cand[s] = word[s +: CODE_W];
  end

  always_comb begin
    if (fmt[2]) sh = MAX_SH;
    else if (int'(fmt[1:0]) > MAX_SH) sh = MAX_SH;
    else sh = int'(fmt[1:0]);
    code = cand[sh];
  end

endmodule

// File: rtl/dacfe_trig.sv
module dacfe_trig
  import dacfe_pkg::*;
#(
  parameter int N_OVF = 3
) (
  input  upd_src_e         src,
  input  logic             hi_wr,
  input  logic [N_OVF-1:0] ovf,
  output logic             fire
);

  logic [N_OVF-1:0] hit;

  for (genvar i = 0; i < N_OVF; i++) begin : g_ovf
    assign hit[i] = ovf[i] && (int'(src) == i + 1);
  end

  assign fire = (|hit) || ((src == UPD_HIWR) && hi_wr);

endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 12,
  parameter int N_OVF  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_sel,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [N_OVF-1:0]  tmr_ovf,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_shdn
);

  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  logic [BYTE_W-1:0] lo_q, hi_q, hi_src;
  ctrl_t             ctrl_q;
  logic              hi_wr, fire;
  logic [CODE_W-1:0] aligned, code_d, code_q;

  dacfe_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk    (clk),
    .srst_n (srst_n),
    .wr_en  (bus_we),
    .sel    (reg_sel_e'(bus_sel)),
    .wdata  (bus_wdata),
    .lo_q   (lo_q),
    .hi_q   (hi_q),
    .ctrl_q (ctrl_q),
    .hi_wr  (hi_wr),
    .rdata  (bus_rdata)
  );

  assign hi_src = hi_wr ? bus_wdata : hi_q;

  dacfe_align #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) u_align (
    .hi_byte (hi_src),
    .lo_byte (lo_q),
    .fmt     (ctrl_q.fmt),
    .code    (aligned)
  );

  dacfe_trig #(.N_OVF(N_OVF)) u_trig (
    .src   (ctrl_q.src),
    .hi_wr (hi_wr),
    .ovf   (tmr_ovf),
    .fire  (fire)
  );

  always_comb begin
    code_d = fire ? aligned : code_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) code_q <= '0;
    else         code_q <= code_d;
  end

  assign dac_code = code_q;
  assign dac_shdn = !ctrl_q.en;

endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk #(
  parameter int BYTE_W = 8,
  parameter int CODE_W = 12,
  parameter int N_OVF  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [1:0]        bus_sel,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic [N_OVF-1:0]  tmr_ovf,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_shdn
);

  logic [1:0] src_sh;
  logic [2:0] fmt_sh;
  logic       hi_ev, ovf_ev, any_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sh <= '0;
      fmt_sh <= '0;
    end else if (bus_we && bus_sel == 2'd2) begin
      src_sh <= bus_wdata[4:3];
      fmt_sh <= bus_wdata[2:0];
    end
  end

  always_comb begin
    hi_ev  = (src_sh == 2'd0) && bus_we && (bus_sel == 2'd1);
    ovf_ev = 1'b0;
    for (int i = 0; i < N_OVF; i++)
      if (int'(src_sh) == i + 1 && tmr_ovf[i]) ovf_ev = 1'b1;
    any_ev = hi_ev || ovf_ev;
  end

  p_shdn_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel == 2'd2) |=> (dac_shdn == !$past(bus_wdata[7])));

  p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == 2'd2) |-> (bus_rdata[6:5] == 2'b00));

  p_none_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == 2'd3) |-> (bus_rdata == '0));

  p_hold_no_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ev |=> $stable(dac_code));

  p_hiwr_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_ev && fmt_sh[2]) |=> (dac_code[CODE_W-1 -: BYTE_W] == $past(bus_wdata)));

endmodule

bind dacfe_top dacfe_chk #(.BYTE_W(BYTE_W), .CODE_W(CODE_W), .N_OVF(N_OVF)) u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .bus_we    (bus_we),
  .bus_sel   (bus_sel),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .tmr_ovf   (tmr_ovf),
  .dac_code  (dac_code),
  .dac_shdn  (dac_shdn)
);

// File: tb/sim_dacfe_top.sv
module sim_dacfe_top;

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_sel;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [2:0]  tmr_ovf;
  logic [11:0] dac_code;
  logic        dac_shdn;

  int total;
  int bad;

  dacfe_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tmr_ovf   (tmr_ovf),
    .dac_code  (dac_code),
    .dac_shdn  (dac_shdn)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [11:0] exp_code(input logic [7:0] hi, input logic [7:0] lo,
                                           input logic [2:0] fmt);
    logic [15:0] w;
    int          s;
    s = fmt[2] ? 4 : int'(fmt[1:0]);
    w = {hi, lo} >> s;
    return w[11:0];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    bus_we = 1'b1; bus_sel = sel; bus_wdata = data;
    @(negedge clk);
    bus_we = 1'b0; bus_sel = 2'd3; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] data);
    @(negedge clk);
    bus_sel = sel;
    #1 data = bus_rdata;
    bus_sel = 2'd3;
  endtask

  task automatic pulse(input logic [2:0] mask);
    @(negedge clk);
    tmr_ovf = mask;
    @(negedge clk);
    tmr_ovf = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  rv;
    logic [11:0] held;
    total = 0; bad = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_sel = 2'd3; bus_wdata = '0; tmr_ovf = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 code", int'(dac_code), 0);
    chk("R1 shdn", int'(dac_shdn), 1);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), rv);
      chk("R1 read", int'(rv), 0);
    end

    // R2 R3 R4 control register
    wr(2'd2, 8'hFF);
    rd(2'd2, rv);
    chk("R3 unused bits read zero", int'(rv), 8'h9F);
    chk("R2 enabled", int'(dac_shdn), 0);
    wr(2'd2, 8'h60);
    rd(2'd2, rv);
    chk("R3 only unused written", int'(rv), 0);
    chk("R2 disabled", int'(dac_shdn), 1);
    wr(2'd3, 8'hA5);
    rd(2'd3, rv);
    chk("R4 none select", int'(rv), 0);
    rd(2'd2, rv);
    chk("R4 select3 write ignored", int'(rv), 0);

    // R5 R6 R8 sweep in high-write mode
    held = '0;
    for (int f = 0; f < 8; f++) begin
      wr(2'd2, 8'h80 | 8'(f));
      rd(2'd2, rv);
      chk("R4 ctrl readback", int'(rv), 8'h80 | f);
      for (int h = 0; h < 16; h++) begin
        for (int l = 0; l < 16; l++) begin
          wr(2'd0, 8'(l * 17) ^ 8'h5C);
          chk("R5 low write holds", int'(dac_code), int'(held));
          wr(2'd1, 8'(h * 17) ^ 8'hC3);
          held = exp_code(8'(h * 17) ^ 8'hC3, 8'(l * 17) ^ 8'h5C, 3'(f));
          chk("R6 R8 high write update", int'(dac_code), int'(held));
        end
      end
    end
    rd(2'd0, rv);
    chk("R4 low readback", int'(rv), (15 * 17) ^ 8'h5C);
    rd(2'd1, rv);
    chk("R4 high readback", int'(rv), (15 * 17) ^ 8'hC3);

    // R7 timer modes
    for (int m = 1; m < 4; m++) begin
      wr(2'd2, 8'h80 | 8'(m << 3));
      wr(2'd0, 8'(8'h21 * m));
      wr(2'd1, 8'(m));
      chk("R7 high write ignored", int'(dac_code), int'(held));
      for (int o = 0; o < 3; o++) begin
        if (o != m - 1) begin
          pulse(3'(1 << o));
          chk("R7 other timer ignored", int'(dac_code), int'(held));
        end
      end
      pulse(3'(1 << (m - 1)));
      held = exp_code(8'(m), 8'(8'h21 * m), 3'd0);
      chk("R7 selected timer update", int'(dac_code), int'(held));
    end

    // R9 format used at event time
    wr(2'd2, 8'h88);
    wr(2'd0, 8'hCD);
    wr(2'd1, 8'hAB);
    wr(2'd2, 8'h8C);
    chk("R9 format change holds", int'(dac_code), int'(held));
    pulse(3'b001);
    chk("R9 format at event", int'(dac_code), int'(exp_code(8'hAB, 8'hCD, 3'd4)));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule